// File: doc/BRIEF.md
# USB Connector Accessory Classifier and Data-Path Router

This controller decides what has been plugged into a USB connector and steers the connector's D+ and D- lines. It can leave them open, send them to the primary host port, or send them to the secondary host port. It takes three digital results from analog front ends: a VBUS-valid flag, a 5-bit code that stands for the ID-pin resistance, and a port classification from a charger-detection front end. It counts every settle delay in ticks of a 1 ms strobe. When a classification completes, it sets two device-type status bytes and the factory-test levels JIG and BOOT, and it emits a one-cycle attach pulse. When the accessory leaves, it clears that state and emits a one-cycle detach pulse.

Routing normally follows the detected accessory. Software can instead select a route for each line with 3-bit manual codes, or force every path open. A route never moves directly from one closed path to a different closed path: it always opens for one cycle in between. While a factory jig is attached, the ID code is watched continuously. A different jig code retargets routing and BOOT in place, and a sustained float ends the session.

Top module: `acc_route_ctrl`

## Requirements
- R1: The ID code is classified as follows. 0x1F means floating. 0x17 is a charger, and a charger is accepted only while `vbus_ok` is high. 0x18, 0x19, 0x1C and 0x1D are factory jigs. Every other code is an unknown accessory. A non-floating code attaches on the ID_MS-th tick after it is first seen.
- R2: `dev_type1` sets bit 6 for a dedicated charging port, bit 5 for a charging downstream port, bit 4 for a charger and bit 2 for a standard downstream port. `dev_type2` sets bit 7 for unknown, bit 3 for UART jig with boot off, bit 2 for UART jig with boot on, bit 1 for USB jig with boot off and bit 0 for USB jig with boot on. Both bytes are zero while nothing is attached.
- R3: Route encoding is 00 open, 01 primary and 10 secondary. UART jigs (0x1C, 0x1D) route to secondary and USB jigs (0x18, 0x19) route to primary. BOOT is high only for 0x19 and 0x1D. JIG is high in every jig mode. Routes settle one cycle after the status bytes.
- R4: With the ID floating and VBUS valid, `port_kind` selects the port type: 01 standard, 10 charging downstream, 11 dedicated charging, 00 not yet known (the controller waits). A standard port attaches on tick SDP_MS and a charging downstream port on tick CDP_MS, both routed to primary. A dedicated charging port attaches on tick SDP_MS with every route open.
- R5: JIG rises on the ID_MS-th tick after a jig code is seen, whether VBUS is present or absent.
- R6: While a jig is attached, a different jig code updates routing, BOOT and `dev_type2` with no attach or detach pulse.
- R7: In a jig mode, a non-jig code held for FLOAT_MS+1 ticks causes a detach. A jig code seen earlier restarts that count.
- R8: With `auto_mode` low, each line follows its own 3-bit code: 000 open, 001 primary, 011 secondary, and any other code open. These codes take effect only while an accessory is attached.
- R9: A route never changes directly between two different non-open values. It spends exactly one cycle open first.
- R10: `force_open` high drives both routes open at the next clock edge, whatever the mode.
- R11: `attach_pulse` and `detach_pulse` last one cycle. Loss of VBUS detaches a USB port or a charger. A non-floating ID detaches a USB port. Any ID change detaches a charger or an unknown accessory.
- R12: A VBUS drop or an ID change while a delay is pending restarts the count from zero.
- R13: After reset, both routes are open, JIG and BOOT are low, both status bytes are zero and no pulse is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ms_tick | input | 1 | One-cycle strobe every millisecond |
| vbus_ok | input | 1 | VBUS above its valid threshold |
| id_code | input | 5 | ID resistance code from the converter |
| port_kind | input | 2 | Charger front-end result: 00 unknown, 01 standard, 10 charging downstream, 11 dedicated |
| auto_mode | input | 1 | 1: routes follow detection, 0: manual codes |
| force_open | input | 1 | Force every route open |
| man_dp | input | 3 | Manual route code for D+ |
| man_dm | input | 3 | Manual route code for D- |
| dp_route | output | 2 | D+ route select |
| dm_route | output | 2 | D- route select |
| jig | output | 1 | Factory jig present (active high) |
| boot | output | 1 | Factory boot-on request |
| dev_type1 | output | 8 | Port and charger type byte |
| dev_type2 | output | 8 | Jig and unknown-accessory type byte |
| attach_pulse | output | 1 | One-cycle attach event |
| detach_pulse | output | 1 | One-cycle detach event |

## Verification
The bench builds the controller with ID_MS=10, SDP_MS=6, CDP_MS=8 and FLOAT_MS=4, and issues one tick every five clocks. At these values the tick on which each attach or detach must land can be bracketed: one tick short of the boundary and exactly on it, for the standard and charging-downstream ports, for JIG, for the float exit and for the restart cases. The whole run still stays to a few thousand cycles. Route changes are watched on every cycle, so any direct move from one closed path to another is caught as well as checked at its expected instants.

// File: rtl/acc_route_pkg.sv
package acc_route_pkg;

    localparam int ID_W = 5;

    typedef enum logic [2:0] {
        IDC_FLOAT,
        IDC_CHARGER,
        IDC_FUSB_OFF,
        IDC_FUSB_ON,
        IDC_FUART_OFF,
        IDC_FUART_ON,
        IDC_UNKNOWN
    } id_class_e;

    typedef enum logic [1:0] {
        RT_OPEN = 2'b00,
        RT_PRI  = 2'b01,
        RT_SEC  = 2'b10
    } route_e;

    typedef enum logic [3:0] {
        ACC_NONE,
        ACC_SDP,
        ACC_CDP,
        ACC_DCP,
        ACC_CHG,
        ACC_UNK,
        ACC_FUSB_OFF,
        ACC_FUSB_ON,
        ACC_FUART_OFF,
        ACC_FUART_ON
    } acc_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ID_WAIT,
        ST_BUS_WAIT,
        ST_LINKED
    } det_state_e;

    localparam logic [1:0] PK_NONE = 2'd0;
    localparam logic [1:0] PK_SDP  = 2'd1;
    localparam logic [1:0] PK_CDP  = 2'd2;
    localparam logic [1:0] PK_DCP  = 2'd3;

    function automatic logic is_factory_acc(acc_e a);
        return a inside {ACC_FUSB_OFF, ACC_FUSB_ON, ACC_FUART_OFF, ACC_FUART_ON};
    endfunction

    function automatic logic is_factory_cls(id_class_e c);
        return c inside {IDC_FUSB_OFF, IDC_FUSB_ON, IDC_FUART_OFF, IDC_FUART_ON};
    endfunction

    function automatic logic is_usb_acc(acc_e a);
        return a inside {ACC_SDP, ACC_CDP, ACC_DCP};
    endfunction

    function automatic logic is_boot_on(acc_e a);
        return a inside {ACC_FUSB_ON, ACC_FUART_ON};
    endfunction

    function automatic acc_e acc_of_class(id_class_e c);
        case (c)
            IDC_CHARGER:   return ACC_CHG;
            IDC_FUSB_OFF:  return ACC_FUSB_OFF;
            IDC_FUSB_ON:   return ACC_FUSB_ON;
            IDC_FUART_OFF: return ACC_FUART_OFF;
            IDC_FUART_ON:  return ACC_FUART_ON;
            IDC_UNKNOWN:   return ACC_UNK;
            default:       return ACC_NONE;
        endcase
    endfunction

    function automatic logic [7:0] type1_of(acc_e a);
        logic [7:0] b;
        b = '0;
        case (a)
            ACC_DCP: b[6] = 1'b1;
            ACC_CDP: b[5] = 1'b1;
            ACC_CHG: b[4] = 1'b1;
            ACC_SDP: b[2] = 1'b1;
            default: b = '0;
        endcase
        return b;
    endfunction

    function automatic logic [7:0] type2_of(acc_e a);
        logic [7:0] b;
        b = '0;
        case (a)
            ACC_UNK:       b[7] = 1'b1;
            ACC_FUART_OFF: b[3] = 1'b1;
            ACC_FUART_ON:  b[2] = 1'b1;
            ACC_FUSB_OFF:  b[1] = 1'b1;
            ACC_FUSB_ON:   b[0] = 1'b1;
            default:       b = '0;
        endcase
        return b;
    endfunction

    function automatic route_e auto_route_of(acc_e a);
        case (a)
            ACC_SDP, ACC_CDP, ACC_FUSB_OFF, ACC_FUSB_ON: return RT_PRI;
            ACC_FUART_OFF, ACC_FUART_ON:                 return RT_SEC;
            default:                                     return RT_OPEN;
        endcase
    endfunction

    function automatic route_e manual_route_of(logic [2:0] code);
        case (code)
            3'b001:  return RT_PRI;
            3'b011:  return RT_SEC;
            default: return RT_OPEN;
        endcase
    endfunction

endpackage

// File: rtl/acc_id_decode.sv
module acc_id_decode
    import acc_route_pkg::*;
(
    input  logic [ID_W-1:0] code,
    output id_class_e       cls
);

    always_comb begin
        case (code)
            5'h1F:   cls = IDC_FLOAT;
            5'h17:   cls = IDC_CHARGER;
            5'h18:   cls = IDC_FUSB_OFF;
            5'h19:   cls = IDC_FUSB_ON;
            5'h1C:   cls = IDC_FUART_OFF;
            5'h1D:   cls = IDC_FUART_ON;
            default: cls = IDC_UNKNOWN;
        endcase
    end

endmodule

// File: rtl/acc_detect_fsm.sv
module acc_detect_fsm
    import acc_route_pkg::*;
#(
    parameter int ID_MS    = 200,
    parameter int SDP_MS   = 130,
    parameter int CDP_MS   = 170,
    parameter int FLOAT_MS = 70
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ms_tick,
    input  logic            vbus_ok,
    input  logic [ID_W-1:0] id_code,
    input  id_class_e       cls,
    input  logic [1:0]      port_kind,
    output acc_e            acc,
    output logic            attach_pulse,
    output logic            detach_pulse
);

    localparam int M1     = (ID_MS > SDP_MS) ? ID_MS : SDP_MS;
    localparam int M2     = (M1 > CDP_MS) ? M1 : CDP_MS;
    localparam int M3     = (M2 > FLOAT_MS + 1) ? M2 : FLOAT_MS + 1;
    localparam int CW     = $clog2(M3 + 1);
    localparam logic [CW-1:0] CNT_TOP = CW'(M3);
    localparam logic [CW-1:0] ID_LIM  = CW'(ID_MS);
    localparam logic [CW-1:0] SDP_LIM = CW'(SDP_MS);
    localparam logic [CW-1:0] CDP_LIM = CW'(CDP_MS);
    localparam logic [CW-1:0] FLT_LIM = CW'(FLOAT_MS);

    typedef struct packed {
        det_state_e      st;
        acc_e            acc;
        logic [ID_W-1:0] id;
        logic [CW-1:0]   cnt;
        logic            att;
        logic            det;
    } fsm_s;

    fsm_s          st_q, st_d;
    logic [CW-1:0] cnt_n;
    logic [CW-1:0] bus_lim;
    acc_e          bus_acc;

    always_comb begin
        st_d     = st_q;
        st_d.att = 1'b0;
        st_d.det = 1'b0;
        cnt_n    = (ms_tick && st_q.cnt != CNT_TOP) ? st_q.cnt + 1'b1 : st_q.cnt;
        bus_lim  = (port_kind == PK_CDP) ? CDP_LIM : SDP_LIM;
        case (port_kind)
            PK_SDP:  bus_acc = ACC_SDP;
            PK_CDP:  bus_acc = ACC_CDP;
            PK_DCP:  bus_acc = ACC_DCP;
            default: bus_acc = ACC_NONE;
        endcase

        case (st_q.st)
            ST_IDLE: begin
                st_d.cnt = '0;
                st_d.id  = id_code;
                if (cls != IDC_FLOAT) begin
                    st_d.st = ST_ID_WAIT;
                end else if (vbus_ok) begin
                    st_d.st = ST_BUS_WAIT;
                end
            end
            ST_ID_WAIT: begin
                if (id_code != st_q.id) begin
                    st_d.cnt = '0;
                    st_d.id  = id_code;
                    if (cls == IDC_FLOAT) st_d.st = ST_IDLE;
                end else if (cls == IDC_CHARGER && !vbus_ok) begin
                    st_d.cnt = '0;
                end else begin
                    st_d.cnt = cnt_n;
                    if (cnt_n >= ID_LIM) begin
                        st_d.st  = ST_LINKED;
                        st_d.acc = acc_of_class(cls);
                        st_d.cnt = '0;
                        st_d.att = 1'b1;
                    end
                end
            end
            ST_BUS_WAIT: begin
                if (!vbus_ok || cls != IDC_FLOAT) begin
                    st_d.st  = ST_IDLE;
                    st_d.cnt = '0;
                end else begin
                    st_d.cnt = cnt_n;
                    if (port_kind != PK_NONE && cnt_n >= bus_lim) begin
                        st_d.st  = ST_LINKED;
                        st_d.acc = bus_acc;
                        st_d.cnt = '0;
                        st_d.att = 1'b1;
                    end
                end
            end
            default: begin
                if (is_factory_acc(st_q.acc)) begin
                    if (is_factory_cls(cls)) begin
                        st_d.acc = acc_of_class(cls);
                        st_d.id  = id_code;
                        st_d.cnt = '0;
                    end else begin
                        st_d.cnt = cnt_n;
                        if (cnt_n > FLT_LIM) st_d.det = 1'b1;
                    end
                end else if (is_usb_acc(st_q.acc)) begin
                    if (!vbus_ok || cls != IDC_FLOAT) st_d.det = 1'b1;
                end else if (st_q.acc == ACC_CHG) begin
                    if (!vbus_ok || id_code != st_q.id) st_d.det = 1'b1;
                end else begin
                    if (id_code != st_q.id) st_d.det = 1'b1;
                end
                if (st_d.det) begin
                    st_d.st  = ST_IDLE;
                    st_d.acc = ACC_NONE;
                    st_d.cnt = '0;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc          = st_q.acc;
    assign attach_pulse = st_q.att;
    assign detach_pulse = st_q.det;

    // R11
    attach_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.att |=> !st_q.att);

    // R11
    detach_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.det |=> !st_q.det);

    // R11
    usb_vbus_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.st == ST_LINKED && is_usb_acc(st_q.acc) && !vbus_ok) |=> st_q.det);

    // R6
    jig_swap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.st == ST_LINKED && is_factory_acc(st_q.acc) && is_factory_cls(cls))
        |=> (!st_q.det && !st_q.att));

endmodule

// File: rtl/acc_route_sel.sv
module acc_route_sel
    import acc_route_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       linked,
    input  logic       auto_mode,
    input  logic       force_open,
    input  route_e     auto_tgt,
    input  logic [2:0] man_code,
    output route_e     route
);

    typedef struct packed {
        route_e rt;
    } sel_s;

    sel_s   sel_q, sel_d;
    route_e want;

    always_comb begin
        if (force_open || !linked) want = RT_OPEN;
        else if (auto_mode)        want = auto_tgt;
        else                       want = manual_route_of(man_code);
        sel_d.rt = want;
        if (sel_q.rt != RT_OPEN && want != RT_OPEN && want != sel_q.rt)
            sel_d.rt = RT_OPEN;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sel_q <= '0;
        else        sel_q <= sel_d;
    end

    assign route = sel_q.rt;

    // R10
    force_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        force_open |=> (route == RT_OPEN));

    // R9
    break_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (route != RT_OPEN) |=> (route == RT_OPEN || route == $past(route)));

    // R8
    unlinked_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !linked |=> (route == RT_OPEN));

endmodule

// File: rtl/acc_route_ctrl.sv
module acc_route_ctrl
    import acc_route_pkg::*;
#(
    parameter int ID_MS    = 200,
    parameter int SDP_MS   = 130,
    parameter int CDP_MS   = 170,
    parameter int FLOAT_MS = 70
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ms_tick,
    input  logic            vbus_ok,
    input  logic [ID_W-1:0] id_code,
    input  logic [1:0]      port_kind,
    input  logic            auto_mode,
    input  logic            force_open,
    input  logic [2:0]      man_dp,
    input  logic [2:0]      man_dm,
    output logic [1:0]      dp_route,
    output logic [1:0]      dm_route,
    output logic            jig,
    output logic            boot,
    output logic [7:0]      dev_type1,
    output logic [7:0]      dev_type2,
    output logic            attach_pulse,
    output logic            detach_pulse
);

    localparam int N_LINES = 2;

    id_class_e  cls;
    acc_e       acc;
    route_e     auto_tgt;
    logic       linked;
    logic [2:0] man_code [N_LINES];
    route_e     line_rt  [N_LINES];

    acc_id_decode u_dec (
        .code (id_code),
        .cls  (cls)
    );

    acc_detect_fsm #(
        .ID_MS    (ID_MS),
        .SDP_MS   (SDP_MS),
        .CDP_MS   (CDP_MS),
        .FLOAT_MS (FLOAT_MS)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .ms_tick      (ms_tick),
        .vbus_ok      (vbus_ok),
        .id_code      (id_code),
        .cls          (cls),
        .port_kind    (port_kind),
        .acc          (acc),
        .attach_pulse (attach_pulse),
        .detach_pulse (detach_pulse)
    );

    always_comb begin
        linked      = (acc != ACC_NONE);
        auto_tgt    = auto_route_of(acc);
        man_code[0] = man_dp;
        man_code[1] = man_dm;
        dev_type1   = type1_of(acc);
        dev_type2   = type2_of(acc);
        jig         = is_factory_acc(acc);
        boot        = is_boot_on(acc);
    end

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        acc_route_sel u_sel (
            .clk        (clk),
            .rst_n      (rst_n),
            .linked     (linked),
            .auto_mode  (auto_mode),
            .force_open (force_open),
            .auto_tgt   (auto_tgt),
            .man_code   (man_code[g]),
            .route      (line_rt[g])
        );
    end

    assign dp_route = line_rt[0];
    assign dm_route = line_rt[1];

endmodule

// File: tb/acc_route_ctrl_test.sv
module acc_route_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int T_ID  = 10;
    localparam int T_SDP = 6;
    localparam int T_CDP = 8;
    localparam int T_FLT = 4;

    typedef struct packed {
        logic       vb;
        logic [4:0] id;
        logic [1:0] pk;
        logic [7:0] t1;
        logic [7:0] t2;
        logic [1:0] rt;
        logic       jg;
        logic       bt;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 5'h1F, 2'd1, 8'h04, 8'h00, 2'd1, 1'b0, 1'b0},
        '{1'b1, 5'h1F, 2'd2, 8'h20, 8'h00, 2'd1, 1'b0, 1'b0},
        '{1'b1, 5'h1F, 2'd3, 8'h40, 8'h00, 2'd0, 1'b0, 1'b0},
        '{1'b1, 5'h17, 2'd0, 8'h10, 8'h00, 2'd0, 1'b0, 1'b0},
        '{1'b0, 5'h17, 2'd0, 8'h00, 8'h00, 2'd0, 1'b0, 1'b0},
        '{1'b0, 5'h18, 2'd0, 8'h00, 8'h02, 2'd1, 1'b1, 1'b0},
        '{1'b1, 5'h19, 2'd0, 8'h00, 8'h01, 2'd1, 1'b1, 1'b1},
        '{1'b0, 5'h1C, 2'd0, 8'h00, 8'h08, 2'd2, 1'b1, 1'b0},
        '{1'b0, 5'h1D, 2'd0, 8'h00, 8'h04, 2'd2, 1'b1, 1'b1},
        '{1'b0, 5'h15, 2'd0, 8'h00, 8'h80, 2'd0, 1'b0, 1'b0},
        '{1'b0, 5'h00, 2'd0, 8'h00, 8'h80, 2'd0, 1'b0, 1'b0},
        '{1'b0, 5'h1F, 2'd1, 8'h00, 8'h00, 2'd0, 1'b0, 1'b0},
        '{1'b1, 5'h1E, 2'd0, 8'h00, 8'h80, 2'd0, 1'b0, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ms_tick = 1'b0;
    logic       vbus_ok = 1'b0;
    logic [4:0] id_code = 5'h1F;
    logic [1:0] port_kind = 2'd0;
    logic       auto_mode = 1'b1;
    logic       force_open = 1'b0;
    logic [2:0] man_dp = 3'b000;
    logic [2:0] man_dm = 3'b000;
    logic [1:0] dp_route, dm_route;
    logic       jig, boot;
    logic [7:0] dev_type1, dev_type2;
    logic       attach_pulse, detach_pulse;

    int checks = 0;
    int fails = 0;
    int att_n = 0;
    int det_n = 0;
    int bbm_bad = 0;
    logic [1:0] prev_dp = 2'b00;
    logic [1:0] prev_dm = 2'b00;

    acc_route_ctrl #(
        .ID_MS    (T_ID),
        .SDP_MS   (T_SDP),
        .CDP_MS   (T_CDP),
        .FLOAT_MS (T_FLT)
    ) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .ms_tick      (ms_tick),
        .vbus_ok      (vbus_ok),
        .id_code      (id_code),
        .port_kind    (port_kind),
        .auto_mode    (auto_mode),
        .force_open   (force_open),
        .man_dp       (man_dp),
        .man_dm       (man_dm),
        .dp_route     (dp_route),
        .dm_route     (dm_route),
        .jig          (jig),
        .boot         (boot),
        .dev_type1    (dev_type1),
        .dev_type2    (dev_type2),
        .attach_pulse (attach_pulse),
        .detach_pulse (detach_pulse)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(negedge clk) begin
        if (attach_pulse) att_n++;
        if (detach_pulse) det_n++;
        if (prev_dp != 2'b00 && dp_route != 2'b00 && dp_route != prev_dp) bbm_bad++;
        if (prev_dm != 2'b00 && dm_route != 2'b00 && dm_route != prev_dm) bbm_bad++;
        prev_dp <= dp_route;
        prev_dm <= dm_route;
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tick(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk) ms_tick = 1'b1;
            @(negedge clk) ms_tick = 1'b0;
            idle(3);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        vbus_ok = 1'b0; id_code = 5'h1F; port_kind = 2'd0;
        auto_mode = 1'b1; force_open = 1'b0; man_dp = 3'b000; man_dm = 3'b000;
        idle(3);
        rst_n = 1'b1;
        idle(2);
        att_n = 0; det_n = 0; bbm_bad = 0;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R13 watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        // R13 reset state
        do_reset();
        chk("R13 dp_route", {6'd0, dp_route}, 8'h00);
        chk("R13 dm_route", {6'd0, dm_route}, 8'h00);
        chk("R13 jig", {7'd0, jig}, 8'h00);
        chk("R13 boot", {7'd0, boot}, 8'h00);
        chk("R13 dev_type1", dev_type1, 8'h00);
        chk("R13 dev_type2", dev_type2, 8'h00);
        chk("R13 pulses", {6'd0, attach_pulse, detach_pulse}, 8'h00);

        // R1 R2 R3 R4 classification table
        for (int i = 0; i < NV; i++) begin
            do_reset();
            vbus_ok = VECS[i].vb; id_code = VECS[i].id; port_kind = VECS[i].pk;
            idle(2);
            tick(12);
            idle(3);
            chk($sformatf("R2 vec%0d type1", i), dev_type1, VECS[i].t1);
            chk($sformatf("R2 vec%0d type2", i), dev_type2, VECS[i].t2);
            chk($sformatf("R3 R4 vec%0d dp", i), {6'd0, dp_route}, {6'd0, VECS[i].rt});
            chk($sformatf("R3 R4 vec%0d dm", i), {6'd0, dm_route}, {6'd0, VECS[i].rt});
            chk($sformatf("R3 vec%0d jig", i), {7'd0, jig}, {7'd0, VECS[i].jg});
            chk($sformatf("R3 vec%0d boot", i), {7'd0, boot}, {7'd0, VECS[i].bt});
        end

        // R4 standard port timing, R11 single pulse
        do_reset();
        vbus_ok = 1'b1; port_kind = 2'd1;
        idle(2);
        tick(T_SDP - 1);
        chk("R4 sdp before limit", dev_type1, 8'h00);
        tick(1);
        chk("R4 sdp at limit", dev_type1, 8'h04);
        chk("R11 one attach pulse", 8'(att_n), 8'd1);
        idle(2);
        chk("R4 sdp route", {6'd0, dp_route}, 8'h01);

        // R4 charging downstream port timing
        do_reset();
        vbus_ok = 1'b1; port_kind = 2'd2;
        idle(2);
        tick(T_CDP - 1);
        chk("R4 cdp before limit", dev_type1, 8'h00);
        tick(1);
        chk("R4 cdp at limit", dev_type1, 8'h20);

        // R5 jig timing without VBUS
        do_reset();
        id_code = 5'h18;
        idle(2);
        tick(T_ID - 1);
        chk("R5 jig before limit", {7'd0, jig}, 8'h00);
        tick(1);
        chk("R5 jig at limit", {7'd0, jig}, 8'h01);

        // R12 VBUS drop restarts
        do_reset();
        vbus_ok = 1'b1; port_kind = 2'd1;
        idle(2);
        tick(4);
        vbus_ok = 1'b0;
        idle(3);
        vbus_ok = 1'b1;
        idle(2);
        tick(T_SDP - 1);
        chk("R12 vbus restart pending", dev_type1, 8'h00);
        tick(1);
        chk("R12 vbus restart done", dev_type1, 8'h04);

        // R12 ID change restarts
        do_reset();
        id_code = 5'h18;
        idle(2);
        tick(8);
        id_code = 5'h19;
        idle(2);
        tick(T_ID - 1);
        chk("R12 id restart pending", dev_type2, 8'h00);
        tick(1);
        chk("R12 id restart done", dev_type2, 8'h01);
        idle(3);

        // R6 jig swap without events, R9 through open
        att_n = 0; det_n = 0; bbm_bad = 0;
        id_code = 5'h1C;
        idle(4);
        chk("R6 swap type2", dev_type2, 8'h08);
        chk("R6 swap boot", {7'd0, boot}, 8'h00);
        chk("R6 swap jig", {7'd0, jig}, 8'h01);
        chk("R6 swap dp", {6'd0, dp_route}, 8'h02);
        chk("R6 no attach", 8'(att_n), 8'd0);
        chk("R6 no detach", 8'(det_n), 8'd0);
        chk("R9 swap via open", 8'(bbm_bad), 8'd0);

        // R7 float exit, early return restarts count
        id_code = 5'h1F;
        idle(2);
        tick(3);
        id_code = 5'h1C;
        idle(2);
        id_code = 5'h1F;
        idle(2);
        tick(T_FLT);
        chk("R7 float at limit type2", dev_type2, 8'h08);
        chk("R7 float at limit no detach", 8'(det_n), 8'd0);
        tick(1);
        chk("R7 float past limit type2", dev_type2, 8'h00);
        chk("R7 float past limit jig", {7'd0, jig}, 8'h00);
        chk("R7 detach count", 8'(det_n), 8'd1);
        idle(2);
        chk("R7 route open", {6'd0, dp_route}, 8'h00);

        // R8 manual routing
        do_reset();
        auto_mode = 1'b0; man_dp = 3'b011; man_dm = 3'b001;
        vbus_ok = 1'b1; port_kind = 2'd1;
        idle(2);
        tick(3);
        chk("R8 manual before attach", {6'd0, dp_route}, 8'h00);
        tick(3);
        idle(3);
        chk("R8 manual dp secondary", {6'd0, dp_route}, 8'h02);
        chk("R8 manual dm primary", {6'd0, dm_route}, 8'h01);
        man_dp = 3'b111;
        idle(3);
        chk("R8 undefined code open", {6'd0, dp_route}, 8'h00);
        man_dp = 3'b001;
        idle(3);
        chk("R8 manual dp primary", {6'd0, dp_route}, 8'h01);
        bbm_bad = 0;
        man_dp = 3'b011;
        @(negedge clk);
        chk("R9 open step", {6'd0, dp_route}, 8'h00);
        @(negedge clk);
        chk("R9 new route", {6'd0, dp_route}, 8'h02);
        chk("R9 monitor", 8'(bbm_bad), 8'd0);

        // R10 force open
        force_open = 1'b1;
        @(negedge clk);
        chk("R10 dp forced", {6'd0, dp_route}, 8'h00);
        chk("R10 dm forced", {6'd0, dm_route}, 8'h00);
        chk("R10 status kept", dev_type1, 8'h04);
        force_open = 1'b0;
        idle(3);
        chk("R10 released", {6'd0, dp_route}, 8'h02);

        // R11 VBUS loss detaches a port
        det_n = 0;
        vbus_ok = 1'b0;
        idle(2);
        chk("R11 vbus loss detach", 8'(det_n), 8'd1);
        chk("R11 vbus loss type1", dev_type1, 8'h00);
        idle(2);
        chk("R11 vbus loss dm", {6'd0, dm_route}, 8'h00);

        // R11 ID change detaches a charger
        do_reset();
        vbus_ok = 1'b1; id_code = 5'h17;
        idle(2);
        tick(T_ID);
        chk("R1 charger attached", dev_type1, 8'h10);
        id_code = 5'h15;
        idle(2);
        chk("R11 charger id change", 8'(det_n), 8'd1);

        finish_run();
    end

endmodule